// File: doc/BRIEF.md
# I2C Controller Enable Gate with Configuration Lockout

This block sits beside an I2C protocol engine and owns its on/off control. Software sets or clears a one-bit enable request through a simple register write port. The block turns that request into an internal enable for the engine. Switching on is immediate. Switching off is a handshake: the internal enable stays asserted until both the master and the slave state machines report idle. Only then does the engine actually stop.

The block also holds the configuration registers: control word, target address, SDA hold and SDA setup. Writes to them are silently dropped while the controller is on, or while it is still draining toward off, so the engine never sees its settings change mid-transfer. The DMA control register is not locked. The block builds the enable-status word and the bus status word. In both words, some fields are forced to fixed values when the controller is disabled.

The enable sequencer is a three-state machine:
- `EN_OFF`: engine stopped.
- `EN_RUN`: engine running.
- `EN_DRAIN`: request withdrawn, waiting for idle.

Its transitions are:
- START: `EN_OFF`→`EN_RUN`, request is 1.
- STOP: `EN_RUN`→`EN_OFF`, request is 0 and both engines idle.
- HOLD: `EN_RUN`→`EN_DRAIN`, request is 0 and an engine busy.
- DONE: `EN_DRAIN`→`EN_OFF`, both engines idle.
- RESUME: `EN_DRAIN`→`EN_RUN`, request is 1 again.

Top module: `i2c_en_lockout`

## Requirements
- R1: Register select codes are 0 control, 1 target address, 2 SDA hold, 3 SDA setup, 4 DMA control, 5 enable; codes 6 and 7 are ignored. A write with select 5 loads the request from data bit 0 at any time. `enable_q` reads the request in bit 0 and 0 elsewhere.
- R2: On the clock edge after the request reads 1, `core_en` goes to 1. This holds from both `EN_OFF` and `EN_DRAIN`.
- R3: While the request is 0, `core_en` falls on the first clock edge at which `mst_idle` and `slv_idle` are both 1. Until then it stays 1.
- R4: Writes to selects 0 to 3 are dropped when the request is 1 or `core_en` is 1. Otherwise they take effect on that clock edge.
- R5: The control register keeps bits 19:0. Bits 10, 11 and 16 to 19 are read-only and read 0, as do bits 31:20.
- R6: The target address keeps 12 bits, SDA hold 24 bits and SDA setup 8 bits. All higher bits read 0.
- R7: The DMA control register keeps 2 bits and accepts writes whatever the enable state.
- R8: While `core_en` is 1, `en_status` is 3'b001.
- R9: While `core_en` is 0, `en_status[0]` is 0. Bits 2:1 hold the `dis_info` value sampled at the edge where `core_en` fell, and are 0 before any disable.
- R10: `bus_status` bit 0 is `mst_act`|`slv_act`, bit 4 is `rxf_full`, and bits 9:7 are 0. While `core_en` is 1: bit 1 is not-`txf_full`, bit 2 is `txf_empty`, bit 3 is not-`rxf_empty`, and bit 10 is `rx_hold`. While `core_en` is 0: bits 1 and 2 are 1, and bits 3 and 10 are 0.
- R11: Bit 5 of `bus_status` is `mst_act` and bit 6 is `slv_act`. Both are forced to 0 when `core_en` is 0 and both idle flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| mst_act | input | 1 | Master state machine active |
| slv_act | input | 1 | Slave state machine active |
| mst_idle | input | 1 | Master state machine idle |
| slv_idle | input | 1 | Slave state machine idle |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_full | input | 1 | Transmit FIFO full |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rx_hold | input | 1 | Engine holding the bus for receive space |
| dis_info | input | 2 | Engine disable condition flags, captured at disable |
| enable_q | output | 32 | Enable register readback |
| ctrl_q | output | 32 | Control register readback |
| tar_q | output | 32 | Target address readback |
| sda_hold_q | output | 32 | SDA hold readback |
| sda_setup_q | output | 32 | SDA setup readback |
| dma_ctrl_q | output | 32 | DMA control readback |
| core_en | output | 1 | Internal enable to the protocol engine |
| en_status | output | 3 | Enable status word |
| bus_status | output | 11 | Bus and FIFO status word |

## Verification
Some properties are checked by assertions on every cycle:
- a locked write leaves the control and target registers unchanged;
- the internal enable falls only after a cycle with a withdrawn request and both engines idle, and never while an engine is busy;
- the enable-status and bus-status words take their forced values whenever the controller is on or off;
- the disable flags are captured at the falling edge.

Other behaviour is shown only by the bench, which replays mixed random and directed traffic against a cycle model. This covers the exact write masks of each register, the resume path out of draining, dropped select codes, and the exact cycle at which enable rises.

// File: rtl/i2c_en_pkg.sv
package i2c_en_pkg;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_RUN   = 2'd1,
        EN_DRAIN = 2'd2
    } en_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TAR   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HOLD  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_SETUP = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DMA   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_EN    = 3'd5;

    localparam int STAT_W = 11;

endpackage

// File: rtl/i2c_en_fsm.sv
module i2c_en_fsm
    import i2c_en_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       bus_idle,
    input  logic [1:0] dis_info,
    output logic       core_en,
    output logic [2:0] en_status
);

    en_state_e  state_q, state_d;
    logic [1:0] flags_q;
    logic       going_off;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        going_off = 1'b0;
        unique case (state_q)
            EN_OFF: begin
                if (en_req) state_d = EN_RUN;            // START
            end
            EN_RUN: begin
                if (!en_req) begin
                    if (bus_idle) begin
                        state_d   = EN_OFF;              // STOP
                        going_off = 1'b1;
                    end else begin
                        state_d = EN_DRAIN;              // HOLD
                    end
                end
            end
            EN_DRAIN: begin
                if (en_req) begin
                    state_d = EN_RUN;                    // RESUME
                end else if (bus_idle) begin
                    state_d   = EN_OFF;                  // DONE
                    going_off = 1'b1;
                end
            end
            default: state_d = EN_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // disable flags, captured as the engine stops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= 2'b00;
        end else if (going_off) begin
            flags_q <= dis_info;
        end
    end

    // outputs
    always_comb begin
        core_en   = (state_q != EN_OFF);
        en_status = core_en ? 3'b001 : {flags_q, 1'b0};
    end

endmodule

// File: rtl/i2c_en_reg.sv
module i2c_en_reg #(
    parameter int               DATA_W   = 32,
    parameter int               REG_W    = 8,
    parameter logic [REG_W-1:0] WMASK    = '1,
    parameter logic [REG_W-1:0] RST_VAL  = '0,
    parameter bit               LOCKABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              lock,
    input  logic [REG_W-1:0]  wr_val,
    output logic [DATA_W-1:0] rd_q
);

    logic [REG_W-1:0] q;
    logic             accept;

    assign accept = wr_hit & ~(lock & LOCKABLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL & WMASK;
        end else if (accept) begin
            q <= wr_val & WMASK;
        end
    end

    generate
        if (REG_W < DATA_W) begin : g_pad
            assign rd_q = {{(DATA_W-REG_W){1'b0}}, q};
        end else begin : g_full
            assign rd_q = q[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/i2c_en_status.sv
module i2c_en_status
    import i2c_en_pkg::*;
(
    input  logic              core_en,
    input  logic              mst_act,
    input  logic              slv_act,
    input  logic              mst_idle,
    input  logic              slv_idle,
    input  logic              txf_empty,
    input  logic              txf_full,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic              rx_hold,
    output logic [STAT_W-1:0] bus_status
);

    logic quiet_off;

    always_comb begin
        quiet_off      = ~core_en & mst_idle & slv_idle;
        bus_status     = '0;
        bus_status[0]  = mst_act | slv_act;
        bus_status[1]  = core_en ? ~txf_full : 1'b1;
        bus_status[2]  = core_en ? txf_empty : 1'b1;
        bus_status[3]  = core_en & ~rxf_empty;
        bus_status[4]  = rxf_full;
        bus_status[5]  = mst_act & ~quiet_off;
        bus_status[6]  = slv_act & ~quiet_off;
        bus_status[10] = core_en & rx_hold;
    end

endmodule

// File: rtl/i2c_en_lockout.sv
module i2c_en_lockout
    import i2c_en_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CTRL_W  = 20,
    parameter int TAR_W   = 12,
    parameter int HOLD_W  = 24,
    parameter int SETUP_W = 8,
    parameter int DMA_W   = 2,
    parameter logic [CTRL_W-1:0] CTRL_RO = 20'hF0C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mst_act,
    input  logic              slv_act,
    input  logic              mst_idle,
    input  logic              slv_idle,
    input  logic              txf_empty,
    input  logic              txf_full,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic              rx_hold,
    input  logic [1:0]        dis_info,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] tar_q,
    output logic [DATA_W-1:0] sda_hold_q,
    output logic [DATA_W-1:0] sda_setup_q,
    output logic [DATA_W-1:0] dma_ctrl_q,
    output logic              core_en,
    output logic [2:0]        en_status,
    output logic [STAT_W-1:0] bus_status
);

    localparam logic [CTRL_W-1:0] CTRL_WMASK = ~CTRL_RO;

    logic en_req;
    logic cfg_lock;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:HOLD_W];
    assign cfg_lock     = en_req | core_en;
    assign enable_q     = {{(DATA_W-1){1'b0}}, en_req};

    // enable request bit, always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_req <= 1'b0;
        end else if (wr_en && wr_sel == SEL_EN) begin
            en_req <= wr_data[0];
        end
    end

    i2c_en_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .bus_idle  (mst_idle & slv_idle),
        .dis_info  (dis_info),
        .core_en   (core_en),
        .en_status (en_status)
    );

    i2c_en_reg #(.DATA_W(DATA_W), .REG_W(CTRL_W), .WMASK(CTRL_WMASK),
                 .RST_VAL('0), .LOCKABLE(1'b1)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_sel == SEL_CTRL),
        .lock(cfg_lock), .wr_val(wr_data[CTRL_W-1:0]), .rd_q(ctrl_q));

    i2c_en_reg #(.DATA_W(DATA_W), .REG_W(TAR_W), .WMASK('1),
                 .RST_VAL('0), .LOCKABLE(1'b1)) u_tar (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_sel == SEL_TAR),
        .lock(cfg_lock), .wr_val(wr_data[TAR_W-1:0]), .rd_q(tar_q));

    i2c_en_reg #(.DATA_W(DATA_W), .REG_W(HOLD_W), .WMASK('1),
                 .RST_VAL('0), .LOCKABLE(1'b1)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_sel == SEL_HOLD),
        .lock(cfg_lock), .wr_val(wr_data[HOLD_W-1:0]), .rd_q(sda_hold_q));

    i2c_en_reg #(.DATA_W(DATA_W), .REG_W(SETUP_W), .WMASK('1),
                 .RST_VAL('0), .LOCKABLE(1'b1)) u_setup (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_sel == SEL_SETUP),
        .lock(cfg_lock), .wr_val(wr_data[SETUP_W-1:0]), .rd_q(sda_setup_q));

    i2c_en_reg #(.DATA_W(DATA_W), .REG_W(DMA_W), .WMASK('1),
                 .RST_VAL('0), .LOCKABLE(1'b0)) u_dma (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_sel == SEL_DMA),
        .lock(cfg_lock), .wr_val(wr_data[DMA_W-1:0]), .rd_q(dma_ctrl_q));

    i2c_en_status u_stat (
        .core_en    (core_en),
        .mst_act    (mst_act),
        .slv_act    (slv_act),
        .mst_idle   (mst_idle),
        .slv_idle   (slv_idle),
        .txf_empty  (txf_empty),
        .txf_full   (txf_full),
        .rxf_empty  (rxf_empty),
        .rxf_full   (rxf_full),
        .rx_hold    (rx_hold),
        .bus_status (bus_status)
    );

endmodule

// File: rtl/i2c_en_lockout_chk.sv
module i2c_en_lockout_chk
    import i2c_en_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic              en_req,
    input logic              cfg_lock,
    input logic              mst_idle,
    input logic              slv_idle,
    input logic [1:0]        dis_info,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       tar_q,
    input logic              core_en,
    input logic [2:0]        en_status,
    input logic [STAT_W-1:0] bus_status
);

    a_r3_fall_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_en) |-> $past(mst_idle && slv_idle && !en_req));

    a_r3_busy_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !(mst_idle && slv_idle)) |=> core_en);

    a_r4_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && wr_en && wr_sel == SEL_CTRL) |=> $stable(ctrl_q));

    a_r4_tar_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && wr_en && wr_sel == SEL_TAR) |=> $stable(tar_q));

    a_r8_on_status: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (en_status == 3'b001));

    a_r9_flags_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_en) |-> (en_status == {$past(dis_info), 1'b0}));

    a_r10_off_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> (bus_status[2:1] == 2'b11 && !bus_status[3] && !bus_status[10]));

    a_r11_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_en && mst_idle && slv_idle) |-> (bus_status[6:5] == 2'b00));

endmodule

bind i2c_en_lockout i2c_en_lockout_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .en_req     (en_req),
    .cfg_lock   (cfg_lock),
    .mst_idle   (mst_idle),
    .slv_idle   (slv_idle),
    .dis_info   (dis_info),
    .ctrl_q     (ctrl_q),
    .tar_q      (tar_q),
    .core_en    (core_en),
    .en_status  (en_status),
    .bus_status (bus_status)
);

// File: tb/i2c_en_lockout_tb.sv
module i2c_en_lockout_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        mst_act = 0, slv_act = 0, mst_idle = 1, slv_idle = 1;
    logic        txf_empty = 1, txf_full = 0, rxf_empty = 1, rxf_full = 0;
    logic        rx_hold = 0;
    logic [1:0]  dis_info = '0;
    logic [31:0] enable_q, ctrl_q, tar_q, sda_hold_q, sda_setup_q, dma_ctrl_q;
    logic        core_en;
    logic [2:0]  en_status;
    logic [10:0] bus_status;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state
    logic        m_req, m_en, m_drain;
    logic [1:0]  m_flags;
    logic [31:0] m_ctrl, m_tar, m_hold, m_setup, m_dma;

    always #5 clk = ~clk;

    i2c_en_lockout u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mst_act(mst_act), .slv_act(slv_act), .mst_idle(mst_idle), .slv_idle(slv_idle),
        .txf_empty(txf_empty), .txf_full(txf_full), .rxf_empty(rxf_empty),
        .rxf_full(rxf_full), .rx_hold(rx_hold), .dis_info(dis_info),
        .enable_q(enable_q), .ctrl_q(ctrl_q), .tar_q(tar_q), .sda_hold_q(sda_hold_q),
        .sda_setup_q(sda_setup_q), .dma_ctrl_q(dma_ctrl_q), .core_en(core_en),
        .en_status(en_status), .bus_status(bus_status)
    );

    function automatic logic [10:0] exp_status();
        logic [10:0] s = '0;
        logic quiet = !m_en && mst_idle && slv_idle;
        s[0]  = mst_act | slv_act;
        s[1]  = m_en ? !txf_full : 1'b1;
        s[2]  = m_en ? txf_empty : 1'b1;
        s[3]  = m_en && !rxf_empty;
        s[4]  = rxf_full;
        s[5]  = mst_act && !quiet;
        s[6]  = slv_act && !quiet;
        s[10] = m_en && rx_hold;
        return s;
    endfunction

    function automatic logic [2:0] exp_en_status();
        return m_en ? 3'b001 : {m_flags, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_req = 0; m_en = 0; m_drain = 0; m_flags = 0;
        m_ctrl = 0; m_tar = 0; m_hold = 0; m_setup = 0; m_dma = 0;
    endtask

    task automatic model_clock();
        logic lock = m_req | m_en;
        logic idle = mst_idle & slv_idle;
        logic n_req = m_req;
        if (wr_en) begin
            case (wr_sel)
                3'd0: if (!lock) m_ctrl = wr_data & 32'h0000_F3FF;
                3'd1: if (!lock) m_tar = wr_data & 32'h0000_0FFF;
                3'd2: if (!lock) m_hold = wr_data & 32'h00FF_FFFF;
                3'd3: if (!lock) m_setup = wr_data & 32'h0000_00FF;
                3'd4: m_dma = wr_data & 32'h3;
                3'd5: n_req = wr_data[0];
                default: ;
            endcase
        end
        if (!m_en) begin
            if (m_req) m_en = 1;
        end else if (m_req) begin
            m_drain = 0;
        end else if (idle) begin
            m_en = 0; m_drain = 0; m_flags = dis_info;
        end else begin
            m_drain = 1;
        end
        m_req = n_req;
    endtask

    task automatic check_all();
        chk("R1", enable_q, {31'b0, m_req});
        chk(m_en ? "R2 R3 on" : "R2 R3 off", {31'b0, core_en}, {31'b0, m_en});
        chk("R4 R5 ctrl", ctrl_q, m_ctrl);
        chk("R4 R6 tar", tar_q, m_tar);
        chk("R4 R6 hold", sda_hold_q, m_hold);
        chk("R4 R6 setup", sda_setup_q, m_setup);
        chk("R7", dma_ctrl_q, m_dma);
        chk(m_en ? "R8" : "R9", {29'b0, en_status}, {29'b0, exp_en_status()});
        chk("R10", {21'b0, bus_status}, {21'b0, exp_status()});
        chk("R11", {30'b0, bus_status[6:5]}, {30'b0, exp_status()[6:5]});
    endtask

    // one cycle: drive at negedge, check, then advance model at posedge
    task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] d,
                       input logic mi, input logic si, input logic ma, input logic sa,
                       input logic [3:0] fifo, input logic hold, input logic [1:0] di);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d;
        mst_idle = mi; slv_idle = si; mst_act = ma; slv_act = sa;
        {txf_empty, txf_full, rxf_empty, rxf_full} = fifo;
        rx_hold = hold; dis_info = di;
        #1;
        check_all();
        @(posedge clk);
        model_clock();
    endtask

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd4242);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state
        cyc(0, 0, 0, 1, 1, 0, 0, 4'b1010, 0, 0);
        // R5: write all ones to control while off
        cyc(1, 3'd0, 32'hFFFF_FFFF, 1, 1, 0, 0, 4'b1010, 0, 0);
        cyc(1, 3'd1, 32'hFFFF_FFFF, 1, 1, 0, 0, 4'b1010, 0, 0);
        cyc(1, 3'd2, 32'hFFFF_FFFF, 1, 1, 0, 0, 4'b1010, 0, 0);
        cyc(1, 3'd3, 32'hFFFF_FFFF, 1, 1, 0, 0, 4'b1010, 0, 0);
        // R2: enable, then R4: locked writes
        cyc(1, 3'd5, 32'h1, 1, 1, 0, 0, 4'b1010, 0, 0);
        cyc(1, 3'd0, 32'h0, 1, 1, 1, 0, 4'b0101, 1, 0);
        cyc(1, 3'd1, 32'h0, 0, 1, 1, 0, 4'b0101, 1, 0);
        cyc(1, 3'd4, 32'h2, 0, 1, 1, 0, 4'b0101, 1, 0);
        // R3: disable while master busy -> drain
        cyc(1, 3'd5, 32'h0, 0, 1, 1, 0, 4'b0101, 1, 2'b10);
        for (int k = 0; k < 4; k++) cyc(1, 3'd2, 32'h0, 0, 1, 1, 1, 4'b0101, 1, 2'b10);
        // R2 resume out of drain, then drop again and go idle
        cyc(1, 3'd5, 32'h1, 0, 1, 1, 0, 4'b0101, 1, 2'b01);
        cyc(1, 3'd5, 32'h0, 0, 0, 1, 1, 4'b0101, 1, 2'b01);
        cyc(0, 3'd0, 32'h0, 1, 1, 1, 1, 4'b0101, 1, 2'b11);
        cyc(1, 3'd6, 32'hFFFF_FFFF, 1, 1, 1, 1, 4'b0101, 1, 2'b00);
        cyc(1, 3'd0, 32'h0000_0400, 1, 1, 0, 0, 4'b1010, 0, 2'b00);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d = $urandom;
            logic [2:0]  s = 3'($urandom % 8);
            cyc(($urandom % 2) == 0, s, d,
                ($urandom % 4) != 0, ($urandom % 4) != 0,
                1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 2'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule